// File: doc/BRIEF.md
# Power-up VID start-up sequencer

This block sequences the start-up of a regulator that drives two voltage planes, a core plane and a north-bridge (NB) plane. When the enable input rises, the block samples the two serial-interface pins as a 2-bit boot code. It also samples a mode input that picks between the normal and the fixed-voltage decode table. It then sets both plane targets to the voltage that the code selects and pulses a soft-start request.

Power-good asserts once both planes report regulation for two consecutive clocks. The block then holds the boot voltage and ignores serial commands until the processor-ready input goes high. While ready stays high, each command rewrites the target of one plane. When ready falls, both planes go back to the stored boot voltage. Dropping enable returns everything to idle.

Targets are 8-bit codes in 10 mV steps. For example, 90 means 0.90 V.

Top module: `vid_boot_seq`

## Requirements
- R1: After reset, and on the clock after any cycle with en_i low, pwr_good_o is 0, ss_req_o is 0 and both targets read 0.
- R2: The boot code is {svc_i, svd_i}, and the mode is fixed_mode_i. Both are sampled on the clock where en_i is first seen high. Later changes of these pins have no effect on the boot voltage.
- R3: With fixed_mode_i=0 at capture, boot codes 00, 01, 10 and 11 give targets 110, 100, 90 and 80 (10 mV units).
- R4: With fixed_mode_i=1 at capture, boot codes 00, 01, 10 and 11 give targets 140, 120, 100 and 80.
- R5: On the capture clock, both targets take the boot value and ss_req_o goes high for exactly one cycle.
- R6: pwr_good_o rises only after core_in_reg_i and nb_in_reg_i are both high on two consecutive clocks during soft-start. A single-clock high does not assert it.
- R7: While pwr_good_o is high and cpu_ready_i is low, cmd_valid_i has no effect and both targets stay at the boot value.
- R8: With cpu_ready_i high after power-good, a cmd_valid_i clock loads cmd_tgt_i into the plane that cmd_plane_i selects (0 = core, 1 = NB). The other plane is unchanged.
- R9: When cpu_ready_i falls, both targets return to the stored boot value on that clock, and pwr_good_o stays high.
- R10: Dropping en_i clears the stored code. The next rising edge of enable captures the pins afresh.
- R11: On a clock where cpu_ready_i is low, a command that arrives at the same time is discarded and the boot value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| fixed_mode_i | input | 1 | Selects the fixed-voltage decode table at capture |
| svc_i | input | 1 | Serial clock pin level, boot code bit 1 |
| svd_i | input | 1 | Serial data pin level, boot code bit 0 |
| cpu_ready_i | input | 1 | Processor ready |
| cmd_valid_i | input | 1 | Decoded serial set-voltage command strobe |
| cmd_plane_i | input | 1 | Command plane: 0 core, 1 NB |
| cmd_tgt_i | input | 8 | Command target, 10 mV units |
| core_in_reg_i | input | 1 | Core plane in regulation |
| nb_in_reg_i | input | 1 | NB plane in regulation |
| core_tgt_o | output | 8 | Core target, 10 mV units |
| nb_tgt_o | output | 8 | NB target, 10 mV units |
| ss_req_o | output | 1 | One-cycle soft-start request |
| pwr_good_o | output | 1 | Power good |

## Verification
The assertions check the following on every cycle:
- the idle clearing after enable drops;
- the single-cycle width of the soft-start pulse;
- the two-clock qualification in front of power-good;
- that the targets stay frozen while power-good is high and ready is low.

Only the directed scenarios can show the decode values of both tables. The same holds for:
- which plane a command lands in;
- that pins toggled after capture are not taken up on restore;
- that a command arriving on the same clock as a ready drop is discarded.

// File: rtl/vid_boot_pkg.sv
package vid_boot_pkg;
  localparam int TGT_W        = 8;
  localparam int LSB_MV       = 10;
  localparam int NORM_TOP_MV  = 1100;
  localparam int NORM_STEP_MV = 100;
  localparam int FIX_TOP_MV   = 1400;
  localparam int FIX_STEP_MV  = 200;

  typedef enum logic [1:0] {ST_IDLE, ST_SOFT, ST_HOLD, ST_RUN} seq_st_e;

  function automatic logic [TGT_W-1:0] boot_tgt(input logic fixed, input logic [1:0] code);
    int mv;
    mv = fixed ? FIX_TOP_MV - FIX_STEP_MV * int'(code)
               : NORM_TOP_MV - NORM_STEP_MV * int'(code);
    return TGT_W'(mv / LSB_MV);
  endfunction
endpackage

// File: rtl/vid_boot_latch.sv
module vid_boot_latch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       svc_i,
  input  logic       svd_i,
  input  logic       fixed_i,
  output logic       en_rise_o,
  output logic [1:0] code_o,
  output logic       fixed_o
);
  logic en_q;

  assign en_rise_o = en_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      code_o  <= '0;
      fixed_o <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        code_o  <= '0;
        fixed_o <= 1'b0;
      end else if (en_rise_o) begin
        code_o  <= {svc_i, svd_i};
        fixed_o <= fixed_i;
      end
    end
  end
endmodule

// File: rtl/vid_boot_pgfilt.sv
module vid_boot_pgfilt #(
  parameter int PG_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic core_ok_i,
  input  logic nb_ok_i,
  output logic done_o
);
  localparam int CW = $clog2(PG_CYCLES + 1);
  logic [CW-1:0] cnt_q;
  logic          ok;

  assign ok     = core_ok_i & nb_ok_i;
  assign done_o = ~clr_i & ok & (cnt_q == CW'(PG_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (clr_i || !ok)                  cnt_q <= '0;
    else if (cnt_q != CW'(PG_CYCLES))       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vid_boot_tgt.sv
module vid_boot_tgt #(
  parameter int TGT_W  = 8,
  parameter int PLANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [TGT_W-1:0] boot_val_i,
  input  logic             wr_i,
  input  logic [$clog2(PLANES)-1:0] wr_sel_i,
  input  logic [TGT_W-1:0] wr_val_i,
  output logic [PLANES-1:0][TGT_W-1:0] tgt_o
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               tgt_o[p] <= '0;
      else if (clear_i)                          tgt_o[p] <= '0;
      else if (load_i)                           tgt_o[p] <= boot_val_i;
      else if (wr_i && (int'(wr_sel_i) == p))    tgt_o[p] <= wr_val_i;
    end
  end
endmodule

// File: rtl/vid_boot_seq.sv
module vid_boot_seq
  import vid_boot_pkg::*;
#(
  parameter int PG_CYCLES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fixed_mode_i,
  input  logic             svc_i,
  input  logic             svd_i,
  input  logic             cpu_ready_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_plane_i,
  input  logic [TGT_W-1:0] cmd_tgt_i,
  input  logic             core_in_reg_i,
  input  logic             nb_in_reg_i,
  output logic [TGT_W-1:0] core_tgt_o,
  output logic [TGT_W-1:0] nb_tgt_o,
  output logic             ss_req_o,
  output logic             pwr_good_o
);
  localparam int PLANES = 2;

  seq_st_e st_q, st_d;
  logic en_rise, fixed_q, pg_done, load, wr;
  logic [1:0] code_q;
  logic [TGT_W-1:0] boot_val;
  logic [PLANES-1:0][TGT_W-1:0] tgt;

  vid_boot_latch u_latch (
    .clk_i, .rst_ni, .en_i, .svc_i, .svd_i,
    .fixed_i(fixed_mode_i), .en_rise_o(en_rise), .code_o(code_q), .fixed_o(fixed_q)
  );

  vid_boot_pgfilt #(.PG_CYCLES(PG_CYCLES)) u_pgfilt (
    .clk_i, .rst_ni, .clr_i(st_q != ST_SOFT),
    .core_ok_i(core_in_reg_i), .nb_ok_i(nb_in_reg_i), .done_o(pg_done)
  );

  // on the capture clock the latch is not yet loaded: decode the pins directly
  assign boot_val = en_rise ? boot_tgt(fixed_mode_i, {svc_i, svd_i})
                            : boot_tgt(fixed_q, code_q);

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    wr   = 1'b0;
    if (!en_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: if (en_rise) begin st_d = ST_SOFT; load = 1'b1; end
        ST_SOFT: if (pg_done) st_d = ST_HOLD;
        ST_HOLD: if (cpu_ready_i) st_d = ST_RUN;
        ST_RUN: begin
          if (!cpu_ready_i) begin st_d = ST_HOLD; load = 1'b1; end
          else if (cmd_valid_i) wr = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ss_req_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      ss_req_o <= (st_q == ST_IDLE) && (st_d == ST_SOFT);
    end
  end

  vid_boot_tgt #(.TGT_W(TGT_W), .PLANES(PLANES)) u_tgt (
    .clk_i, .rst_ni, .clear_i(!en_i), .load_i(load), .boot_val_i(boot_val),
    .wr_i(wr), .wr_sel_i(cmd_plane_i), .wr_val_i(cmd_tgt_i), .tgt_o(tgt)
  );

  assign core_tgt_o = tgt[0];
  assign nb_tgt_o   = tgt[1];
  assign pwr_good_o = (st_q == ST_HOLD) || (st_q == ST_RUN);
endmodule

// File: rtl/vid_boot_chk.sv
module vid_boot_chk #(
  parameter int TGT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             cpu_ready_i,
  input logic             core_in_reg_i,
  input logic             nb_in_reg_i,
  input logic [TGT_W-1:0] core_tgt_o,
  input logic [TGT_W-1:0] nb_tgt_o,
  input logic             ss_req_o,
  input logic             pwr_good_o
);
  a_r1_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pwr_good_o && !ss_req_o && core_tgt_o == '0 && nb_tgt_o == '0));

  a_r5_ss_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_req_o |=> !ss_req_o);

  a_r6_pg_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_good_o) |-> ($past(core_in_reg_i && nb_in_reg_i) &&
                           $past(core_in_reg_i && nb_in_reg_i, 2)));

  a_r7_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && pwr_good_o && $past(pwr_good_o) &&
     !$past(cpu_ready_i) && !$past(cpu_ready_i, 2))
    |-> ($stable(core_tgt_o) && $stable(nb_tgt_o)));

  a_r10_pg_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_good_o |-> $past(en_i));
endmodule

bind vid_boot_seq vid_boot_chk #(.TGT_W(vid_boot_pkg::TGT_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .cpu_ready_i, .core_in_reg_i, .nb_in_reg_i,
  .core_tgt_o, .nb_tgt_o, .ss_req_o, .pwr_good_o
);

// File: tb/sim_vid_boot_seq.sv
`timescale 1ns/1ps
module sim_vid_boot_seq;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, fixed_mode_i = 0, svc_i = 0, svd_i = 0, cpu_ready_i = 0;
  logic cmd_valid_i = 0, cmd_plane_i = 0, core_in_reg_i = 0, nb_in_reg_i = 0;
  logic [7:0] cmd_tgt_i = '0;
  logic [7:0] core_tgt_o, nb_tgt_o;
  logic ss_req_o, pwr_good_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  vid_boot_seq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk_i); endtask

  function automatic int exp_boot(input bit fx, input int code);
    int nrm[4] = '{110, 100, 90, 80};
    int fix[4] = '{140, 120, 100, 80};
    return fx ? fix[code] : nrm[code];
  endfunction

  task automatic t_reset();
    chk("R1 pg", pwr_good_o, 0);
    chk("R1 core", core_tgt_o, 0);
    chk("R1 nb", nb_tgt_o, 0);
    chk("R1 ss", ss_req_o, 0);
  endtask

  task automatic t_boot(input bit fx, input int code);
    svc_i = code[1]; svd_i = code[0]; fixed_mode_i = fx; en_i = 1;
    step();
    chk(fx ? "R4 core" : "R3 core", core_tgt_o, exp_boot(fx, code));
    chk(fx ? "R4 nb" : "R3 nb", nb_tgt_o, exp_boot(fx, code));
    chk("R5 ss high", ss_req_o, 1);
    step();
    chk("R5 ss low", ss_req_o, 0);
  endtask

  task automatic t_pg_glitch();
    core_in_reg_i = 1; nb_in_reg_i = 1; step();
    core_in_reg_i = 0; step();
    chk("R6 glitch", pwr_good_o, 0);
    core_in_reg_i = 1; step();
    chk("R6 first", pwr_good_o, 0);
    step();
    chk("R6 second", pwr_good_o, 1);
  endtask

  task automatic t_hold_ignore(input int exp);
    cmd_valid_i = 1; cmd_plane_i = 0; cmd_tgt_i = 8'd55;
    repeat (3) step();
    cmd_valid_i = 0;
    chk("R7 core", core_tgt_o, exp);
    chk("R7 nb", nb_tgt_o, exp);
  endtask

  task automatic t_run_cmds(input int boot);
    cpu_ready_i = 1; step();
    cmd_valid_i = 1; cmd_plane_i = 0; cmd_tgt_i = 8'd123; step();
    chk("R8 core", core_tgt_o, 123);
    chk("R8 nb kept", nb_tgt_o, boot);
    cmd_plane_i = 1; cmd_tgt_i = 8'd75; step();
    cmd_valid_i = 0;
    chk("R8 nb", nb_tgt_o, 75);
    chk("R8 core kept", core_tgt_o, 123);
  endtask

  task automatic t_ready_drop(input int boot);
    svc_i = ~svc_i; svd_i = ~svd_i; fixed_mode_i = ~fixed_mode_i;
    cpu_ready_i = 0; cmd_valid_i = 1; cmd_plane_i = 0; cmd_tgt_i = 8'd200;
    step();
    cmd_valid_i = 0;
    chk("R9/R11/R2 core", core_tgt_o, boot);
    chk("R9/R2 nb", nb_tgt_o, boot);
    chk("R9 pg", pwr_good_o, 1);
    t_hold_ignore(boot);
  endtask

  task automatic t_disable();
    en_i = 0; core_in_reg_i = 0; nb_in_reg_i = 0; step();
    chk("R10 pg", pwr_good_o, 0);
    chk("R10 core", core_tgt_o, 0);
    chk("R10 nb", nb_tgt_o, 0);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_ni = 1; step();
    t_reset();
    t_boot(0, 2);
    t_pg_glitch();
    t_hold_ignore(90);
    t_run_cmds(90);
    t_ready_drop(90);
    t_disable();
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++) begin
        t_boot(bit'(m), c);   // R10: each enable recaptures
        t_disable();
      end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule